// File: doc/BRIEF.md
# One-Time-Programmable Memory Byte Programming Sequencer

This block drives the programming pins of an external one-time-programmable memory. A host gives it a command, an address and a data byte, and pulses a start strobe. The block then runs the whole pin sequence for that command. For a write, it presents the address and data, selects the mode and raises the enable control line. After the enable has settled it turns on the programming-voltage switch and sends a train of active-low program pulses. It then holds the voltage, drops it, and keeps the address and data stable for a closing interval. For a read-back, it presents the address with the enable low, waits for the memory's access time, and captures the returned byte.

All timing comes from parameters. Setup and hold intervals are counted in periods of `clk`, which is assumed to be the oscillator of the programming interface. Microsecond intervals are counted by a single down counter loaded from a cycles-per-microsecond parameter. Code-array writes use a short pulse train. Writes to the encryption table or to a lock bit use a long pulse train. The block raises `done_o` for one clock when it returns to idle. It takes a new start in that same cycle, so commands can run back to back.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, `prog_n_o`=1, `vpp_en_o`=0, `ena_o`=0, `done_o`=0, and `addr_o`, `data_o`, `mode_o`, `vdata_o` are all zero.
- R2: Command encoding on `cmd_i`: 0 = write code byte, 1 = write encryption byte, 2 = write lock bit, 3 = read-back. From the cycle after an accepted start, `mode_o` shows the captured command for the whole sequence.
- R3: A code-byte write produces exactly CODE_PULSES low pulses on `prog_n_o` (default 5). An encryption or lock write produces exactly AUX_PULSES (default 25).
- R4: For a write, `ena_o` rises in the cycle after the accepted start. `vpp_en_o` rises exactly SETUP_CYC cycles later (default 48).
- R5: `vpp_en_o` is high for exactly VPP_US*CYC_PER_US cycles before the first falling edge of `prog_n_o`. `prog_n_o` is never low while `vpp_en_o` is low.
- R6: Every low pulse on `prog_n_o` lasts PULSE_US*CYC_PER_US cycles. Every high gap between two pulses lasts GAP_US*CYC_PER_US cycles.
- R7: After the last rising edge of `prog_n_o`, `vpp_en_o` stays high for VPP_US*CYC_PER_US cycles. `ena_o` then stays high for SETUP_CYC more cycles before the block goes idle.
- R8: `done_o` is high for exactly one cycle, in the first idle cycle after a sequence.
- R9: A read-back keeps `ena_o` and `vpp_en_o` low and makes no pulses. It samples `rd_data_i` SETUP_CYC cycles after the address is applied, and shows the sampled byte on `vdata_o` together with `done_o`. `vdata_o` keeps that byte through later write sequences.
- R10: A start is ignored in every non-idle cycle, including the last cycle before `done_o`. A start is accepted in the cycle where `done_o` is high.
- R11: `addr_o` and `data_o` keep the captured values, unchanged, from the cycle after the start until idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| cmd_i | input | 2 | Command code (see R2) |
| addr_i | input | ADDR_W | Target address |
| data_i | input | DATA_W | Byte to write |
| rd_data_i | input | DATA_W | Byte returned by the memory during read-back |
| addr_o | output | ADDR_W | Address lines to the memory |
| data_o | output | DATA_W | Data lines to the memory |
| mode_o | output | 2 | Mode control lines (captured command) |
| ena_o | output | 1 | Enable control line, high during writes |
| vpp_en_o | output | 1 | Programming-voltage switch enable |
| prog_n_o | output | 1 | Active-low program pulse |
| done_o | output | 1 | One-cycle completion pulse |
| vdata_o | output | DATA_W | Last byte read back |

## Verification
Completion of one sequence and acceptance of the next can fall in the same cycle: the idle cycle that carries `done_o` also samples `start_i`. The bench drives a read-back start in exactly the `done_o` cycle of a code-byte write. It expects `mode_o` to switch to 3 in the next cycle and the read-back to finish normally. A second test drives a start one cycle earlier, in the final hold cycle. That start must leave `mode_o`, `addr_o` and `ena_o` unchanged once the block is idle.

// File: rtl/eprom_seq_pkg.sv
// Package: shared command codes and sequencer state encoding.
// Assumes the command encoding is fixed by the host interface (R2).
package eprom_seq_pkg;
    typedef enum logic [1:0] {
        CMD_CODE   = 2'd0,
        CMD_CRYPT  = 2'd1,
        CMD_LOCK   = 2'd2,
        CMD_VERIFY = 2'd3
    } seq_cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LEAD,
        ST_LOW,
        ST_GAP,
        ST_TAIL,
        ST_HOLD,
        ST_VREAD
    } seq_state_t;
endpackage

// File: rtl/eprom_seq_timer.sv
// Module: down counter that times every interval of the sequence.
// Assumes the load value is the interval length minus one; zero_o marks the last cycle.
module eprom_seq_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= load_val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/eprom_seq_ctrl.sv
// Module: state machine that orders setup, voltage, pulse train, tail and hold.
// Assumes the timer reports zero in the last cycle of each loaded interval.
module eprom_seq_ctrl
    import eprom_seq_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int T_SETUP     = 48,
    parameter int T_VPP       = 40,
    parameter int T_LOW       = 400,
    parameter int T_GAP       = 40,
    parameter int CODE_PULSES = 5,
    parameter int AUX_PULSES  = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       cmd_i,
    input  logic             tmr_zero_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             capture_o,
    output logic             sample_o,
    output logic             idle_o,
    output logic             ena_o,
    output logic             vpp_en_o,
    output logic             prog_n_o,
    output logic             done_o
);
    localparam int PC_W = $clog2(AUX_PULSES + 1);
    localparam logic [CNT_W-1:0] V_SETUP = CNT_W'(T_SETUP - 1);
    localparam logic [CNT_W-1:0] V_VPP   = CNT_W'(T_VPP - 1);
    localparam logic [CNT_W-1:0] V_LOW   = CNT_W'(T_LOW - 1);
    localparam logic [CNT_W-1:0] V_GAP   = CNT_W'(T_GAP - 1);

    seq_state_t      state_q, state_d;
    logic [PC_W-1:0] pulses_q;
    logic            done_q;

    // Next-state and timer-load decode.
    always_comb begin
        state_d   = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d    = (cmd_i == CMD_VERIFY) ? ST_VREAD : ST_SETUP;
                tmr_load_o = 1'b1;
                tmr_val_o  = V_SETUP;
            end
            ST_SETUP: if (tmr_zero_i) begin
                state_d = ST_LEAD; tmr_load_o = 1'b1; tmr_val_o = V_VPP;
            end
            ST_LEAD: if (tmr_zero_i) begin
                state_d = ST_LOW; tmr_load_o = 1'b1; tmr_val_o = V_LOW;
            end
            ST_LOW: if (tmr_zero_i) begin
                tmr_load_o = 1'b1;
                if (pulses_q == PC_W'(1)) begin
                    state_d = ST_TAIL; tmr_val_o = V_VPP;
                end else begin
                    state_d = ST_GAP;  tmr_val_o = V_GAP;
                end
            end
            ST_GAP: if (tmr_zero_i) begin
                state_d = ST_LOW; tmr_load_o = 1'b1; tmr_val_o = V_LOW;
            end
            ST_TAIL: if (tmr_zero_i) begin
                state_d = ST_HOLD; tmr_load_o = 1'b1; tmr_val_o = V_SETUP;
            end
            ST_HOLD:  if (tmr_zero_i) state_d = ST_IDLE;
            ST_VREAD: if (tmr_zero_i) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and one-cycle completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
        end
    end

    // Remaining-pulse counter, loaded per target and decremented at each pulse end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulses_q <= '0;
        else if (capture_o)
            pulses_q <= (cmd_i == CMD_CODE) ? PC_W'(CODE_PULSES) : PC_W'(AUX_PULSES);
        else if (state_q == ST_LOW && tmr_zero_i)
            pulses_q <= pulses_q - 1'b1;
    end

    assign idle_o    = (state_q == ST_IDLE);
    assign capture_o = idle_o && start_i;
    assign sample_o  = (state_q == ST_VREAD) && tmr_zero_i;
    assign ena_o     = (state_q != ST_IDLE) && (state_q != ST_VREAD);
    assign vpp_en_o  = (state_q == ST_LEAD) || (state_q == ST_LOW) ||
                       (state_q == ST_GAP)  || (state_q == ST_TAIL);
    assign prog_n_o  = (state_q != ST_LOW);
    assign done_o    = done_q;
endmodule

// File: rtl/eprom_prog_seq.sv
// Module: top of the programming sequencer; holds the pin-side registers.
// Assumes clk is the programming oscillator and CYC_PER_US clocks make one microsecond.
module eprom_prog_seq
    import eprom_seq_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int SETUP_CYC   = 48,
    parameter int CYC_PER_US  = 4,
    parameter int PULSE_US    = 100,
    parameter int GAP_US      = 10,
    parameter int VPP_US      = 10,
    parameter int CODE_PULSES = 5,
    parameter int AUX_PULSES  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [1:0]        mode_o,
    output logic              ena_o,
    output logic              vpp_en_o,
    output logic              prog_n_o,
    output logic              done_o,
    output logic [DATA_W-1:0] vdata_o
);
    localparam int T_VPP  = VPP_US * CYC_PER_US;
    localparam int T_LOW  = PULSE_US * CYC_PER_US;
    localparam int T_GAP  = GAP_US * CYC_PER_US;
    localparam int T_MAX  = (T_LOW > SETUP_CYC) ? T_LOW : SETUP_CYC;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic             tmr_load, tmr_zero, capture, sample, idle_w;
    logic [CNT_W-1:0] tmr_val;

    eprom_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .zero_o(tmr_zero)
    );

    eprom_seq_ctrl #(
        .CNT_W(CNT_W), .T_SETUP(SETUP_CYC), .T_VPP(T_VPP), .T_LOW(T_LOW),
        .T_GAP(T_GAP), .CODE_PULSES(CODE_PULSES), .AUX_PULSES(AUX_PULSES)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .capture_o(capture), .sample_o(sample), .idle_o(idle_w),
        .ena_o(ena_o), .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o), .done_o(done_o)
    );

    // Capture address, data and mode when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            data_o <= '0;
            mode_o <= '0;
        end else if (capture) begin
            addr_o <= addr_i;
            data_o <= data_i;
            mode_o <= cmd_i;
        end
    end

    // Latch the read-back byte at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)      vdata_o <= '0;
        else if (sample) vdata_o <= rd_data_i;
    end
endmodule

// File: rtl/eprom_prog_seq_chk.sv
// Module: protocol checker for the programming sequencer, bound to the top.
// Assumes T_LOW is the pulse length in clocks; pulse width is checked with a run counter.
module eprom_prog_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int T_LOW  = 400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              idle_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] data_o,
    input logic [1:0]        mode_o,
    input logic              ena_o,
    input logic              vpp_en_o,
    input logic              prog_n_o,
    input logic              done_o
);
    int low_run;

    // Count consecutive low cycles of the program pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || prog_n_o) low_run <= 0;
        else                    low_run <= low_run + 1;
    end

    // R6
    prog_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n_o) |-> low_run == T_LOW);
    // R5
    pulse_needs_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> vpp_en_o);
    // R4
    vpp_after_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_en_o) |-> ena_o && $past(ena_o));
    // R7
    enable_outlives_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vpp_en_o) |-> ena_o);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    verify_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd3 |-> !vpp_en_o && prog_n_o && !ena_o);
    // R11
    lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i && !$past(idle_i) |-> $stable(addr_o) && $stable(data_o));
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_LOW(PULSE_US * CYC_PER_US)
) chk_i (
    .clk(clk), .rst_n(rst_n), .idle_i(idle_w), .addr_o(addr_o), .data_o(data_o),
    .mode_o(mode_o), .ena_o(ena_o), .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o),
    .done_o(done_o)
);

// File: tb/eprom_prog_seq_tb_top.sv
// Directed bench for the programming sequencer; one task per scenario.
module eprom_prog_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int S   = 48;
    localparam int CPU = 4;
    localparam int V   = 10 * CPU;
    localparam int L   = 100 * CPU;
    localparam int G   = 10 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cmd_i = 2'd0;
    logic [15:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic [7:0]  rd_data_i;
    logic [15:0] addr_o;
    logic [7:0]  data_o, vdata_o;
    logic [1:0]  mode_o;
    logic        ena_o, vpp_en_o, prog_n_o, done_o;
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model for read-back: a fixed function of the presented address.
    assign rd_data_i = addr_o[7:0] ^ addr_o[15:8] ^ 8'hA5;

    eprom_prog_seq #(.SETUP_CYC(S), .CYC_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .addr_i(addr_i), .data_i(data_i), .rd_data_i(rd_data_i),
        .addr_o(addr_o), .data_o(data_o), .mode_o(mode_o), .ena_o(ena_o),
        .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o), .done_o(done_o), .vdata_o(vdata_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Run one write sequence; inj_t>0 drives an extra start at that cycle.
    // Returns at the negedge where done_o is high.
    task automatic run_prog(input logic [1:0] cmd, input logic [15:0] a,
                            input logic [7:0] d, input int np, input int inj_t);
        int t, falls, rises, t_vr, t_vf, t_ff, t_lr, t_lf, t_done, bad_lw, bad_gp, bad_ln;
        logic pp, pv;
        @(negedge clk);
        cmd_i = cmd; addr_i = a; data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        addr_i = ~a; data_i = ~d; cmd_i = 2'd3;
        t = 1; falls = 0; rises = 0; t_vr = -1; t_vf = -1; t_ff = -1; t_lr = -1;
        t_lf = -1; t_done = -1; bad_lw = 0; bad_gp = 0; bad_ln = 0;
        pp = 1'b1; pv = 1'b0;
        chk(ena_o === 1'b1, "R4 enable after start", int'(ena_o), 1);
        chk(mode_o === cmd, "R2 mode lines", int'(mode_o), int'(cmd));
        while (t < 20000) begin
            if (done_o) begin t_done = t; break; end
            if (addr_o !== a || data_o !== d || mode_o !== cmd || !ena_o) bad_ln++;
            if (vpp_en_o && !pv) t_vr = t;
            if (!vpp_en_o && pv) t_vf = t;
            if (!prog_n_o && pp) begin
                falls++;
                if (falls == 1) t_ff = t;
                else if (t - t_lr != G) bad_gp++;
                t_lf = t;
            end
            if (prog_n_o && !pp) begin
                rises++;
                if (t - t_lf != L) bad_lw++;
                t_lr = t;
            end
            pp = prog_n_o; pv = vpp_en_o;
            if (inj_t > 0 && t == inj_t) begin cmd_i = 2'd3; start_i = 1'b1; end
            else start_i = 1'b0;
            @(negedge clk);
            t++;
        end
        start_i = 1'b0;
        chk(t_done > 0, "R8 sequence completes", t_done, 1);
        chk(bad_ln == 0, "R11 lines held", bad_ln, 0);
        chk(falls == np && rises == np, "R3 pulse count", falls, np);
        chk(t_vr == 1 + S, "R4 vpp rise cycle", t_vr, 1 + S);
        chk(t_ff - t_vr == V, "R5 vpp lead", t_ff - t_vr, V);
        chk(bad_lw == 0, "R6 low width", bad_lw, 0);
        chk(bad_gp == 0, "R6 gap width", bad_gp, 0);
        chk(t_vf - t_lr == V, "R7 vpp tail", t_vf - t_lr, V);
        chk(t_done - t_vf == S, "R7 address hold", t_done - t_vf, S);
        chk(ena_o === 1'b0 && vpp_en_o === 1'b0, "R8 idle at done", int'(ena_o), 0);
    endtask

    // Read-back; the start is driven at the current negedge by the caller or here.
    task automatic run_verify(input logic [15:0] a, input bit already_started);
        int t, t_done, bad;
        logic [7:0] expv;
        if (!already_started) begin
            @(negedge clk);
            cmd_i = 2'd3; addr_i = a; start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        expv = a[7:0] ^ a[15:8] ^ 8'hA5;
        t = 1; t_done = -1; bad = 0;
        chk(mode_o === 2'd3, "R2 verify mode", int'(mode_o), 3);
        while (t < 1000) begin
            if (done_o) begin t_done = t; break; end
            if (ena_o || vpp_en_o || !prog_n_o) bad++;
            @(negedge clk);
            t++;
        end
        chk(bad == 0, "R9 quiet during verify", bad, 0);
        chk(t_done == 1 + S, "R9 sample time", t_done, 1 + S);
        chk(vdata_o === expv, "R9 read data", int'(vdata_o), int'(expv));
        @(negedge clk);
        chk(done_o === 1'b0, "R8 done one cycle", int'(done_o), 0);
    endtask

    task automatic test_reset();
        chk(prog_n_o === 1'b1 && vpp_en_o === 1'b0 && ena_o === 1'b0 && done_o === 1'b0,
            "R1 control pins", int'(prog_n_o), 1);
        chk(addr_o === '0 && data_o === '0 && mode_o === '0 && vdata_o === '0,
            "R1 data pins", int'(addr_o), 0);
    endtask

    task automatic test_back_to_back();
        run_prog(2'd0, 16'h0123, 8'h5C, 5, 0);
        cmd_i = 2'd3; addr_i = 16'h3F10; start_i = 1'b1;
        run_verify(16'h3F10, 1'b1);
        chk(1'b1, "R10 start taken with done", 0, 0);
    endtask

    task automatic test_late_start();
        int dn;
        dn = 1 + S + V + 5 * L + 4 * G + V + S;
        run_prog(2'd0, 16'h0ABC, 8'h11, 5, dn - 1);
        @(negedge clk);
        chk(mode_o === 2'd0, "R10 late start ignored (mode)", int'(mode_o), 0);
        chk(ena_o === 1'b0 && addr_o === 16'h0ABC, "R10 late start ignored (lines)",
            int'(addr_o), 16'h0ABC);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        run_prog(2'd0, 16'h1234, 8'hA7, 5, 0);
        run_verify(16'h1234, 1'b0);
        run_prog(2'd1, 16'h001F, 8'h3C, 25, 0);
        chk(vdata_o === (8'h34 ^ 8'h12 ^ 8'hA5), "R9 read data kept",
            int'(vdata_o), int'(8'h34 ^ 8'h12 ^ 8'hA5));
        run_prog(2'd2, 16'h0002, 8'hFF, 25, 300);
        test_back_to_back();
        test_late_start();
        finish_run();
    end
endmodule